// File: doc/BRIEF.md
# Nonvolatile Block Write-Protection Guard

This block keeps the protection setting of one 64 KB nonvolatile array and judges, for every program, sector-erase or mass-erase request, whether the target is allowed. Its 8-bit setting comes from a configuration byte presented while reset is held. After reset, software can only make the setting stricter: an open or region-off bit can be cleared but never set again, and a region's size can be picked only while that region is still switched off. A debug-mode input lifts these limits so that a debugger can rewrite every writable field.

Two protected windows can be active at once. The lower one starts at offset 0 and grows upward. The upper one ends at the last byte of the array and grows downward. Each has its own 2-bit size code. A global open bit, when cleared, locks the whole array and makes both windows irrelevant. A request carries a 16-bit offset within the array. One cycle later the guard raises a single-cycle violation pulse if the request falls in locked space.

Top module: `flash_prot_guard`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the setting register loads `cfg_init` in full and `viol` goes low; `prot_q` always shows the register.
- R2: Field positions in the setting byte: bit 7 open (1 = array open), bit 6 reserved flag, bit 5 upper-window off (1 = no upper window), bits 4:3 upper size code, bit 2 lower-window off (1 = no lower window), bits 1:0 lower size code.
- R3: On a write with `dbg_mode` low, bits 7, 5 and 2 each become the AND of their old value and the written value, so they can only move from 1 to 0.
- R4: On a write with `dbg_mode` low, a size code takes the written value only if its own off bit is 1 before that write. Otherwise the size code is unchanged.
- R5: On a write with `dbg_mode` high, every bit except bit 6 takes the written value.
- R6: Bit 6 never changes after reset, whatever is written.
- R7: With bit 7 = 1 and bit 2 = 0, offsets below 512 × 2^(lower size code) are protected. This gives 512 B, 1 KB, 2 KB or 4 KB.
- R8: With bit 7 = 1 and bit 5 = 0, offsets at or above 65536 − 2048 × 2^(upper size code) are protected. This gives 2 KB, 4 KB, 8 KB or 16 KB at the top.
- R9: With bit 7 = 0, every program and sector-erase request violates, whatever its offset and whatever the window fields hold.
- R10: A mass-erase request violates unless bits 7, 5 and 2 are all 1. Its offset is ignored.
- R11: `req_kind` codes: 0 program, 1 sector erase, 2 mass erase, 3 no operation. `viol` is high in the cycle after a `req_valid` cycle whose request violates, judged against the setting held before any write in that same cycle. It is low after every other cycle, including cycles with `req_valid` low and cycles with code 3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; loads `cfg_init` |
| cfg_init | input | 8 | Configuration byte loaded during reset |
| wr_en | input | 1 | Write strobe for the setting register |
| wr_data | input | 8 | Value offered on a write |
| dbg_mode | input | 1 | Debug mode: write limits lifted |
| prot_q | output | 8 | Current setting register |
| req_valid | input | 1 | Request strobe |
| req_kind | input | 2 | Request code (0 program, 1 sector erase, 2 mass erase, 3 none) |
| req_off | input | 16 | Byte offset within the array |
| viol | output | 1 | Registered violation pulse |

## Verification
The bench builds the guard with its defaults: a 16-bit offset, a 512-byte lower unit and a 2048-byte upper unit. With these values, every size code of both windows gives a boundary that the bench can probe on both sides, from the 512-byte edge up to the 16 KB edge that starts at 0xC000. The full one-way write rules are also reachable within a few writes, so locked size codes, refused re-opening and debug overrides can all be driven and compared each cycle against a behavioural model.

// File: rtl/flash_prot_pkg.sv
`timescale 1ns/1ps
// Package: shared types for the protection guard.
// Assumes: an 8-bit setting byte whose field order is fixed by the layout
// below, because the reset-time configuration byte is decoded that way.
package flash_prot_pkg;

    // Request codes carried on req_kind.
    typedef enum logic [1:0] {
        REQ_PROG = 2'd0,
        REQ_SECT = 2'd1,
        REQ_MASS = 2'd2,
        REQ_NONE = 2'd3
    } req_kind_e;

    // Setting byte, MSB first.
    typedef struct packed {
        logic       open;    // 1: array open, windows apply
        logic       rsv;     // reserved flag, fixed after reset
        logic       hi_off;  // 1: no upper window
        logic [1:0] hi_sz;   // upper window size code
        logic       lo_off;  // 1: no lower window
        logic [1:0] lo_sz;   // lower window size code
    } prot_cfg_t;

    localparam int CFG_W  = $bits(prot_cfg_t);
    localparam int SIZE_W = 2;

endpackage

// File: rtl/prot_cfg_reg.sv
`timescale 1ns/1ps
// Module: prot_cfg_reg
// Holds the setting byte. It loads the reset-time byte and applies the
// one-way write rules: enable bits only clear, and a size code changes only
// while its window is off. Debug mode lifts both limits. The reserved flag
// never changes after reset.
// Assumes: wr_data is meaningful only while wr_en is high.
module prot_cfg_reg
    import flash_prot_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  prot_cfg_t  cfg_init,
    input  logic       wr_en,
    input  prot_cfg_t  wr_data,
    input  logic       dbg_mode,
    output prot_cfg_t  cfg_q
);

    prot_cfg_t cfg_nxt;

    // Next setting under the write rules of the current mode.
    always_comb begin
        cfg_nxt = cfg_q;
        if (wr_en) begin
            if (dbg_mode) begin
                cfg_nxt     = wr_data;
                cfg_nxt.rsv = cfg_q.rsv;
            end else begin
                cfg_nxt.open   = cfg_q.open   & wr_data.open;
                cfg_nxt.hi_off = cfg_q.hi_off & wr_data.hi_off;
                cfg_nxt.lo_off = cfg_q.lo_off & wr_data.lo_off;
                if (cfg_q.hi_off) cfg_nxt.hi_sz = wr_data.hi_sz;
                if (cfg_q.lo_off) cfg_nxt.lo_sz = wr_data.lo_sz;
            end
        end
    end

    // Setting register: reset load, else rule-filtered update.
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= cfg_init;
        else        cfg_q <= cfg_nxt;
    end

endmodule

// File: rtl/prot_window_cmp.sv
`timescale 1ns/1ps
// Module: prot_window_cmp
// Tells whether an offset falls inside one window. The window length is
// UNIT_BYTES shifted left by the size code. AT_TOP picks a window that ends
// at the last byte of the array; otherwise it starts at offset 0.
// Assumes: UNIT_BYTES << (2**SIZE_W - 1) does not exceed 2**ADDR_W.
module prot_window_cmp #(
    parameter int ADDR_W     = 16,
    parameter int SIZE_W     = 2,
    parameter int UNIT_BYTES = 512,
    parameter bit AT_TOP     = 1'b0
) (
    input  logic [SIZE_W-1:0] size_sel,
    input  logic [ADDR_W-1:0] off,
    output logic              hit
);

    localparam int             EXT_W  = ADDR_W + 1;
    localparam logic [EXT_W-1:0] UNIT_V = EXT_W'(UNIT_BYTES);
    localparam logic [EXT_W-1:0] SPAN_V = EXT_W'(1) << ADDR_W;

    logic [EXT_W-1:0] win_len;
    logic [EXT_W-1:0] off_ext;

    // Window length and widened offset.
    always_comb begin
        win_len = UNIT_V << size_sel;
        off_ext = {1'b0, off};
    end

    generate
        if (AT_TOP) begin : g_top
            logic [EXT_W-1:0] win_start;
            // Upper window: offset at or above the start.
            always_comb begin
                win_start = SPAN_V - win_len;
                hit       = (off_ext >= win_start);
            end
        end else begin : g_base
            // Lower window: offset below its length.
            always_comb hit = (off_ext < win_len);
        end
    endgenerate

endmodule

// File: rtl/prot_verdict.sv
`timescale 1ns/1ps
// Module: prot_verdict
// Combines the setting with the two window hits for the request code and
// registers a one-cycle violation pulse.
// Assumes: the window hits are for the same offset and setting.
module prot_verdict
    import flash_prot_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      open,
    input  logic      hi_off,
    input  logic      lo_off,
    input  logic      hi_hit,
    input  logic      lo_hit,
    input  logic      req_valid,
    input  req_kind_e req_kind,
    output logic      viol
);

    logic bad;

    // Does the request touch locked space.
    always_comb begin
        unique case (req_kind)
            REQ_PROG, REQ_SECT: bad = !open | (!lo_off & lo_hit) | (!hi_off & hi_hit);
            REQ_MASS:           bad = !(open & lo_off & hi_off);
            default:            bad = 1'b0;
        endcase
    end

    // Registered pulse, qualified by the request strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) viol <= 1'b0;
        else        viol <= req_valid & bad;
    end

endmodule

// File: rtl/flash_prot_guard.sv
`timescale 1ns/1ps
// Module: flash_prot_guard (top)
// Protection guard for one nonvolatile array: it holds the setting register
// and gives a one-cycle verdict on program and erase requests.
// Assumes: req_off is the byte offset within the array; paging is resolved
// upstream.
module flash_prot_guard
    import flash_prot_pkg::*;
#(
    parameter int ADDR_W  = 16,
    parameter int LO_UNIT = 512,
    parameter int HI_UNIT = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [7:0]        cfg_init,
    input  logic              wr_en,
    input  logic [7:0]        wr_data,
    input  logic              dbg_mode,
    output logic [7:0]        prot_q,
    input  logic              req_valid,
    input  logic [1:0]        req_kind,
    input  logic [ADDR_W-1:0] req_off,
    output logic              viol
);

    prot_cfg_t cfg_q;
    logic      lo_hit;
    logic      hi_hit;

    prot_cfg_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .cfg_init (prot_cfg_t'(cfg_init)),
        .wr_en    (wr_en),
        .wr_data  (prot_cfg_t'(wr_data)),
        .dbg_mode (dbg_mode),
        .cfg_q    (cfg_q)
    );

    prot_window_cmp #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .UNIT_BYTES(LO_UNIT), .AT_TOP(1'b0)
    ) u_lo (
        .size_sel (cfg_q.lo_sz),
        .off      (req_off),
        .hit      (lo_hit)
    );

    prot_window_cmp #(
        .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .UNIT_BYTES(HI_UNIT), .AT_TOP(1'b1)
    ) u_hi (
        .size_sel (cfg_q.hi_sz),
        .off      (req_off),
        .hit      (hi_hit)
    );

    prot_verdict u_verdict (
        .clk       (clk),
        .rst_n     (rst_n),
        .open      (cfg_q.open),
        .hi_off    (cfg_q.hi_off),
        .lo_off    (cfg_q.lo_off),
        .hi_hit    (hi_hit),
        .lo_hit    (lo_hit),
        .req_valid (req_valid),
        .req_kind  (req_kind_e'(req_kind)),
        .viol      (viol)
    );

    // Setting is visible as a plain byte.
    always_comb prot_q = CFG_W'(cfg_q);

endmodule

// File: rtl/flash_prot_guard_chk.sv
`timescale 1ns/1ps
// Module: flash_prot_guard_chk
// Assertion checker bound to flash_prot_guard. It watches the port-level
// behaviour of the setting register and the verdict pulse.
module flash_prot_guard_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       dbg_mode,
    input logic [7:0] prot_q,
    input logic       req_valid,
    input logic [1:0] req_kind,
    input logic       viol
);

    // R3: outside debug, open and off bits never rise.
    assert_oneway_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !dbg_mode |=> !((prot_q[7] && !$past(prot_q[7])) ||
                        (prot_q[5] && !$past(prot_q[5])) ||
                        (prot_q[2] && !$past(prot_q[2]))));

    // R4: upper size code frozen while the upper window is on.
    assert_hisize_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_mode && !prot_q[5]) |=> $stable(prot_q[4:3]));

    // R4: lower size code frozen while the lower window is on.
    assert_losize_lock_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!dbg_mode && !prot_q[2]) |=> $stable(prot_q[1:0]));

    // R6: reserved flag fixed outside reset.
    assert_rsv_fixed_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(prot_q[6]));

    // R9: closed array rejects every program and sector erase.
    assert_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_kind[1] && !prot_q[7]) |=> viol);

    // R10: mass erase verdict depends only on the three enable bits.
    assert_mass_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_kind == 2'd2) |=>
            (viol == !($past(prot_q[7]) && $past(prot_q[5]) && $past(prot_q[2]))));

    // R11: no pulse without a real request.
    assert_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (!req_valid || req_kind == 2'd3) |=> !viol);

endmodule

bind flash_prot_guard flash_prot_guard_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dbg_mode  (dbg_mode),
    .prot_q    (prot_q),
    .req_valid (req_valid),
    .req_kind  (req_kind),
    .viol      (viol)
);

// File: tb/flash_prot_guard_bench.sv
`timescale 1ns/1ps
// Bench: behavioural reference model compared every clock, plus directed
// expectations at the window boundaries.
module flash_prot_guard_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cfg_init = 8'hFF;
    logic        wr_en = 1'b0;
    logic [7:0]  wr_data = 8'h00;
    logic        dbg_mode = 1'b0;
    logic [7:0]  prot_q;
    logic        req_valid = 1'b0;
    logic [1:0]  req_kind = 2'd3;
    logic [15:0] req_off = 16'h0000;
    logic        viol;

    int    n_chk = 0;
    int    n_fail = 0;
    bit    armed = 1'b0;
    string tag = "R1";

    logic [7:0] m_reg = 8'h00;
    bit         m_viol = 1'b0;

    always #5 clk = ~clk;

    flash_prot_guard u_flash_prot_guard (
        .clk(clk), .rst_n(rst_n), .cfg_init(cfg_init), .wr_en(wr_en),
        .wr_data(wr_data), .dbg_mode(dbg_mode), .prot_q(prot_q),
        .req_valid(req_valid), .req_kind(req_kind), .req_off(req_off),
        .viol(viol)
    );

    // Model verdict from the requirement text (R7 to R11).
    function automatic bit model_bad(int kind, int off, logic [7:0] r);
        int lo_len = 512 * (2 ** int'(r[1:0]));
        int hi_beg = 65536 - 2048 * (2 ** int'(r[4:3]));
        if (kind == 2) return !(r[7] && r[5] && r[2]);
        if (kind == 3) return 1'b0;
        if (!r[7]) return 1'b1;
        if (!r[2] && off < lo_len) return 1'b1;
        if (!r[5] && off >= hi_beg) return 1'b1;
        return 1'b0;
    endfunction

    // Reference model step (R1, R3 to R6, R11).
    always @(posedge clk) begin
        armed = 1'b1;
        if (!rst_n) begin
            m_reg  = cfg_init;
            m_viol = 1'b0;
        end else begin
            m_viol = req_valid && model_bad(int'(req_kind), int'(req_off), m_reg);
            if (wr_en) begin
                if (dbg_mode) begin
                    m_reg = (wr_data & 8'hBF) | (m_reg & 8'h40);
                end else begin
                    logic [7:0] n;
                    n = m_reg;
                    if (!wr_data[7]) n[7] = 1'b0;
                    if (!wr_data[5]) n[5] = 1'b0;
                    if (!wr_data[2]) n[2] = 1'b0;
                    if (m_reg[5]) n[4:3] = wr_data[4:3];
                    if (m_reg[2]) n[1:0] = wr_data[1:0];
                    m_reg = n;
                end
            end
        end
    end

    task automatic check(bit ok, string t, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", t, act, exp, $time);
        end
    endtask

    // Per-clock comparison against the model, away from the active edge.
    always @(negedge clk) begin
        if (armed) begin
            check(prot_q === m_reg, {tag, " prot_q"}, int'(prot_q), int'(m_reg));
            check(viol === m_viol, {tag, " viol"}, int'(viol), int'(m_viol));
        end
    end

    task automatic wr(logic [7:0] d, bit dbg);
        wr_en = 1'b1; wr_data = d; dbg_mode = dbg;
        @(negedge clk);
        wr_en = 1'b0; dbg_mode = 1'b0;
    endtask

    task automatic req(bit v, logic [1:0] k, logic [15:0] o, bit exp, string t);
        req_valid = v; req_kind = k; req_off = o;
        @(negedge clk);
        check(viol === exp, {t, " directed viol"}, int'(viol), int'(exp));
        req_valid = 1'b0; req_kind = 2'd3;
    endtask

    task automatic expect_q(logic [7:0] exp, string t);
        check(prot_q === exp, {t, " directed prot_q"}, int'(prot_q), int'(exp));
    endtask

    initial begin
        // R1: reset load of an all-open byte.
        repeat (2) @(negedge clk);
        expect_q(8'hFF, "R1");
        check(viol === 1'b0, "R1 viol", int'(viol), 0);
        rst_n = 1'b1;

        // R2, R4: pick lower size 2 (2 KB) while open, then switch it on.
        tag = "R2";
        wr(8'hFE, 1'b0); expect_q(8'hFE, "R4");
        wr(8'hFA, 1'b0); expect_q(8'hFA, "R2");

        // R7: lower window edges at 0 and 0x07FF, free at 0x0800.
        tag = "R7";
        req(1'b1, 2'd0, 16'h0000, 1'b1, "R7");
        req(1'b1, 2'd0, 16'h07FF, 1'b1, "R7");
        req(1'b1, 2'd1, 16'h0800, 1'b0, "R7");

        // R4: locked lower size refuses a new code.
        tag = "R4";
        wr(8'hF9, 1'b0); expect_q(8'hFA, "R4");
        // R3: off bit cannot be set back to 1.
        tag = "R3";
        wr(8'hFF, 1'b0); expect_q(8'hFA, "R3");

        // R8: upper size 1 (4 KB), then switch it on.
        tag = "R8";
        wr(8'hEA, 1'b0); expect_q(8'hEA, "R8");
        wr(8'hCA, 1'b0); expect_q(8'hCA, "R8");
        req(1'b1, 2'd0, 16'hF000, 1'b1, "R8");
        req(1'b1, 2'd1, 16'hEFFF, 1'b0, "R8");
        req(1'b1, 2'd0, 16'hFFFF, 1'b1, "R8");
        req(1'b1, 2'd0, 16'h1000, 1'b0, "R8");

        // R10: mass erase blocked while any window is on.
        tag = "R10";
        req(1'b1, 2'd2, 16'h8000, 1'b1, "R10");

        // R11: no strobe, or the no-op code, never pulse.
        tag = "R11";
        req(1'b0, 2'd0, 16'h0000, 1'b0, "R11");
        req(1'b1, 2'd3, 16'h0000, 1'b0, "R11");

        // R9: closing the array rejects all program and sector erase.
        tag = "R9";
        wr(8'h4A, 1'b0); expect_q(8'h4A, "R9");
        req(1'b1, 2'd0, 16'h8000, 1'b1, "R9");
        req(1'b1, 2'd1, 16'h1000, 1'b1, "R9");

        // R5: debug write reopens everything; reserved flag stays 1.
        tag = "R5";
        wr(8'hBF, 1'b1); expect_q(8'hFF, "R5");
        req(1'b1, 2'd2, 16'h1234, 1'b0, "R10");
        req(1'b1, 2'd0, 16'h0000, 1'b0, "R5");

        // R6: reset with reserved flag 0, debug write of 1 leaves it 0.
        tag = "R6";
        rst_n = 1'b0; cfg_init = 8'hB5;
        @(negedge clk);
        expect_q(8'hB5, "R1");
        rst_n = 1'b1;
        wr(8'hFF, 1'b1); expect_q(8'hBF, "R6");

        // R7, R8: every size code, both sides of each edge.
        for (int s = 0; s < 4; s++) begin
            logic [7:0] c;
            int lo_len;
            int hi_beg;
            c = 8'h80 | 8'(s << 3) | 8'(s);
            lo_len = 512 << s;
            hi_beg = 65536 - (2048 << s);
            tag = "R7";
            wr(c, 1'b1);
            req(1'b1, 2'd0, 16'(lo_len - 1), 1'b1, "R7");
            req(1'b1, 2'd0, 16'(lo_len), 1'b0, "R7");
            tag = "R8";
            req(1'b1, 2'd1, 16'(hi_beg), 1'b1, "R8");
            req(1'b1, 2'd1, 16'(hi_beg - 1), 1'b0, "R8");
        end
        tag = "R10";
        wr(8'hA0, 1'b1);
        req(1'b1, 2'd2, 16'h4000, 1'b1, "R10");

        // Mixed traffic against the model.
        tag = "R11";
        for (int i = 0; i < 400; i++) begin
            logic [31:0] r;
            r = $urandom;
            wr_en     = r[0];
            dbg_mode  = (r[3:1] == 3'd0);
            wr_data   = r[11:4];
            req_valid = r[12];
            req_kind  = r[14:13];
            req_off   = r[31:16];
            @(negedge clk);
        end
        wr_en = 1'b0; req_valid = 1'b0; dbg_mode = 1'b0;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog R11 actual=timeout expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule